// File: doc/BRIEF.md
# Streaming Packet Byte Buffer

This block holds outgoing and incoming packet bytes between a host and a radio engine. It has two separate byte FIFOs of 16 entries each. One carries bytes toward the transmitter and the other carries bytes from the receiver. A packet that fits in 16 bytes can be loaded in one burst, started, and sent with no further host action. Longer packets, up to 255 bytes, stream through the same storage. The host refills the transmit side or drains the receive side whenever a level flag asks it to.

Each direction tracks progress against its own 8-bit packet length, separate from the buffer occupancy. The transmit side counts bytes handed to the radio and finishes when that count reaches the length loaded by the start strobe. The receive side counts bytes arriving from the radio and finishes when that count reaches the length announced at frame start.

While the radio engine sends or receives acknowledgement frames, it raises an ACK-phase input. During that phase the buffers are left untouched.

Top module: `pkt_stream_buf`

## Requirements
- R1: Each buffer holds 16 bytes. A host write to a full transmit buffer is dropped, so `txLevel` stays at 16. A host read from an empty receive buffer is ignored.
- R2: After `txGo` with a length of 1 to 16, the bytes already loaded are sent with no further host writes. `txDoneFlag` rises in the cycle after the pop that brings the sent count up to the length. A length of 0 sets `txDoneFlag` at once.
- R3: Radio pops present bytes on `radTxData` in host write order. This holds for lengths up to 255 when the host refills the buffer while the packet is being sent.
- R4: `txRoomFlag` is 1 exactly when at least 8 transmit entries are free.
- R5: `rxHalfFlag` is 1 exactly when at least 8 receive entries are occupied.
- R6: `hostRdData` shows received bytes in arrival order. `rxDoneFlag` rises when the received count equals the length given with `rxStart`.
- R7: A radio push while the receive buffer is full drops the byte but still counts it toward the length. It sets `rxOverflowErr`, which stays set until the next `rxStart`.
- R8: A radio pop while a packet is active and the transmit buffer is empty sets `txUnderrunErr` and does not advance the sent count. The error stays set until the next `txGo`.
- R9: While `ackMode` is 1, radio pops and pushes are ignored. Both buffer levels and contents are unchanged by them.
- R10: A pop with no active transmit packet, or a push with no active receive packet, is ignored. A pop or push in the same cycle as the matching start strobe is also ignored.
- R11: After reset both levels are 0, `txRoomFlag` is 1, and every other flag and error is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host writes one byte into the transmit buffer |
| hostWrData | input | 8 | Byte written by the host |
| txGo | input | 1 | Start a transmit packet of length `txLenIn` |
| txLenIn | input | 8 | Transmit packet length, 0 to 255 |
| hostRdEn | input | 1 | Host removes the head byte of the receive buffer |
| hostRdData | output | 8 | Head byte of the receive buffer |
| radTxPop | input | 1 | Radio takes the head transmit byte |
| radTxData | output | 8 | Head byte of the transmit buffer |
| rxStart | input | 1 | Radio announces a new received frame |
| rxLenIn | input | 8 | Length field of the received frame |
| radRxPush | input | 1 | Radio delivers one received byte |
| radRxData | input | 8 | Received byte |
| ackMode | input | 1 | Radio is handling an ACK frame; buffer traffic is frozen |
| txLevel | output | 5 | Transmit buffer occupancy |
| rxLevel | output | 5 | Receive buffer occupancy |
| txRoomFlag | output | 1 | At least 8 transmit entries are free |
| rxHalfFlag | output | 1 | At least 8 receive entries are occupied |
| txDoneFlag | output | 1 | Transmit packet fully handed to the radio |
| rxDoneFlag | output | 1 | Received count reached the frame length |
| txUnderrunErr | output | 1 | Sticky: radio popped from an empty buffer mid-packet |
| rxOverflowErr | output | 1 | Sticky: a received byte was dropped because the buffer was full |

## Verification
The embedded properties check the following on every cycle:
- No FIFO is written when full or read when empty.
- The overflow and underrun errors set on the right event and stay sticky.
- The per-packet counters never reach their lengths while a packet is active.
- `ackMode` freezes both levels.

Byte ordering across buffer wrap-around and across refills during long packets can only be shown by the bench's reference queues. The same holds for the exact cycle in which each done flag rises and for the interplay of host and radio traffic in the same cycle.

// File: rtl/pkt_buf_pkg.sv
package pkt_buf_pkg;

  // Strobes from control to datapath, one per FIFO port
  typedef struct packed {
    logic txWrite;
    logic txRead;
    logic rxWrite;
    logic rxRead;
  } bufStrobe_t;

endpackage

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [DATA_W-1:0]            wrData,
  input  logic                         rdEn,
  output logic [DATA_W-1:0]            rdData,
  output logic [$clog2(DEPTH+1)-1:0]   level
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);
  localparam logic [LVL_W-1:0] FULL_L = LVL_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (wrEn) wrPtr <= (wrPtr == LAST_P) ? '0 : wrPtr + 1'b1;
      if (rdEn) rdPtr <= (rdPtr == LAST_P) ? '0 : rdPtr + 1'b1;
      case ({wrEn, rdEn})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R1: control never writes a full buffer nor reads an empty one
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> level != FULL_L);
  a_r1_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> level != '0);
  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    level <= FULL_L);

endmodule

// File: rtl/pkt_buf_dp.sv
module pkt_buf_dp
  import pkt_buf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  bufStrobe_t                 strobe,
  input  logic [DATA_W-1:0]          hostWrData,
  input  logic [DATA_W-1:0]          radRxData,
  output logic [DATA_W-1:0]          radTxData,
  output logic [DATA_W-1:0]          hostRdData,
  output logic [$clog2(DEPTH+1)-1:0] txLevel,
  output logic [$clog2(DEPTH+1)-1:0] rxLevel
);

  pkt_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txFifo (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (strobe.txWrite),
    .wrData (hostWrData),
    .rdEn   (strobe.txRead),
    .rdData (radTxData),
    .level  (txLevel)
  );

  pkt_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxFifo (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (strobe.rxWrite),
    .wrData (radRxData),
    .rdEn   (strobe.rxRead),
    .rdData (hostRdData),
    .level  (rxLevel)
  );

endmodule

// File: rtl/pkt_buf_ctrl.sv
module pkt_buf_ctrl
  import pkt_buf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int LEN_W  = 8,
  parameter int THRESH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       hostWrEn,
  input  logic                       hostRdEn,
  input  logic                       txGo,
  input  logic [LEN_W-1:0]           txLenIn,
  input  logic                       radTxPop,
  input  logic                       rxStart,
  input  logic [LEN_W-1:0]           rxLenIn,
  input  logic                       radRxPush,
  input  logic                       ackMode,
  input  logic [$clog2(DEPTH+1)-1:0] txLevel,
  input  logic [$clog2(DEPTH+1)-1:0] rxLevel,
  output bufStrobe_t                 strobe,
  output logic                       txRoomFlag,
  output logic                       rxHalfFlag,
  output logic                       txDoneFlag,
  output logic                       rxDoneFlag,
  output logic                       txUnderrunErr,
  output logic                       rxOverflowErr
);
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam logic [LVL_W-1:0] FULL_L   = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] THRESH_L = LVL_W'(THRESH);
  localparam logic [LVL_W-1:0] ROOM_MAX = LVL_W'(DEPTH - THRESH);
  localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);

  logic             txActive, rxActive;
  logic [LEN_W-1:0] txLen, txSent, rxLen, rxCnt;
  logic             popLive, pushLive;

  // A radio event counts only inside a packet, outside the ACK phase,
  // and not in the same cycle as a restart of that direction.
  always_comb begin
    popLive        = radTxPop  && txActive && !ackMode && !txGo;
    pushLive       = radRxPush && rxActive && !ackMode && !rxStart;
    strobe.txWrite = hostWrEn && (txLevel != FULL_L);
    strobe.txRead  = popLive  && (txLevel != '0);
    strobe.rxWrite = pushLive && (rxLevel != FULL_L);
    strobe.rxRead  = hostRdEn && (rxLevel != '0);
  end

  assign txRoomFlag = (txLevel <= ROOM_MAX);
  assign rxHalfFlag = (rxLevel >= THRESH_L);

  // Transmit packet tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txActive      <= 1'b0;
      txLen         <= '0;
      txSent        <= '0;
      txDoneFlag    <= 1'b0;
      txUnderrunErr <= 1'b0;
    end else if (txGo) begin
      txLen         <= txLenIn;
      txSent        <= '0;
      txActive      <= (txLenIn != '0);
      txDoneFlag    <= (txLenIn == '0);
      txUnderrunErr <= 1'b0;
    end else if (popLive) begin
      if (txLevel == '0) begin
        txUnderrunErr <= 1'b1;
      end else begin
        txSent <= txSent + LEN_ONE;
        if (txSent == txLen - LEN_ONE) begin
          txActive   <= 1'b0;
          txDoneFlag <= 1'b1;
        end
      end
    end
  end

  // Receive packet tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxActive      <= 1'b0;
      rxLen         <= '0;
      rxCnt         <= '0;
      rxDoneFlag    <= 1'b0;
      rxOverflowErr <= 1'b0;
    end else if (rxStart) begin
      rxLen         <= rxLenIn;
      rxCnt         <= '0;
      rxActive      <= (rxLenIn != '0);
      rxDoneFlag    <= (rxLenIn == '0);
      rxOverflowErr <= 1'b0;
    end else if (pushLive) begin
      rxCnt <= rxCnt + LEN_ONE;
      if (rxLevel == FULL_L) rxOverflowErr <= 1'b1;
      if (rxCnt == rxLen - LEN_ONE) begin
        rxActive   <= 1'b0;
        rxDoneFlag <= 1'b1;
      end
    end
  end

  // R9: ACK phase leaves both buffers as they were
  a_r9_ack_tx_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (ackMode && !hostWrEn) |=> txLevel == $past(txLevel));
  a_r9_ack_rx_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (ackMode && !hostRdEn) |=> rxLevel == $past(rxLevel));

  // R7: overflow is set by a push into a full buffer and stays sticky
  a_r7_overflow_set: assert property (@(posedge clk) disable iff (!rstN)
    (radRxPush && rxActive && !ackMode && !rxStart && rxLevel == FULL_L)
      |=> rxOverflowErr);
  a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (rxOverflowErr && !rxStart) |=> rxOverflowErr);

  // R8: underrun is set by a pop from an empty buffer mid-packet and sticks
  a_r8_underrun_set: assert property (@(posedge clk) disable iff (!rstN)
    (radTxPop && txActive && !ackMode && !txGo && txLevel == '0)
      |=> txUnderrunErr);
  a_r8_underrun_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (txUnderrunErr && !txGo) |=> txUnderrunErr);

  // R2 / R6: counters stay below the length while a packet is open
  a_r2_tx_count: assert property (@(posedge clk) disable iff (!rstN)
    txActive |-> txSent < txLen);
  a_r6_rx_count: assert property (@(posedge clk) disable iff (!rstN)
    rxActive |-> rxCnt < rxLen);

endmodule

// File: rtl/pkt_stream_buf.sv
module pkt_stream_buf
  import pkt_buf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int LEN_W  = 8,
  parameter int THRESH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              txGo,
  input  logic [LEN_W-1:0]  txLenIn,
  input  logic              hostRdEn,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              radTxPop,
  output logic [DATA_W-1:0] radTxData,
  input  logic              rxStart,
  input  logic [LEN_W-1:0]  rxLenIn,
  input  logic              radRxPush,
  input  logic [DATA_W-1:0] radRxData,
  input  logic              ackMode,
  output logic [LVL_W-1:0]  txLevel,
  output logic [LVL_W-1:0]  rxLevel,
  output logic              txRoomFlag,
  output logic              rxHalfFlag,
  output logic              txDoneFlag,
  output logic              rxDoneFlag,
  output logic              txUnderrunErr,
  output logic              rxOverflowErr
);

  bufStrobe_t strobe;

  pkt_buf_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W), .THRESH(THRESH)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .hostWrEn      (hostWrEn),
    .hostRdEn      (hostRdEn),
    .txGo          (txGo),
    .txLenIn       (txLenIn),
    .radTxPop      (radTxPop),
    .rxStart       (rxStart),
    .rxLenIn       (rxLenIn),
    .radRxPush     (radRxPush),
    .ackMode       (ackMode),
    .txLevel       (txLevel),
    .rxLevel       (rxLevel),
    .strobe        (strobe),
    .txRoomFlag    (txRoomFlag),
    .rxHalfFlag    (rxHalfFlag),
    .txDoneFlag    (txDoneFlag),
    .rxDoneFlag    (rxDoneFlag),
    .txUnderrunErr (txUnderrunErr),
    .rxOverflowErr (rxOverflowErr)
  );

  pkt_buf_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .hostWrData (hostWrData),
    .radRxData  (radRxData),
    .radTxData  (radTxData),
    .hostRdData (hostRdData),
    .txLevel    (txLevel),
    .rxLevel    (rxLevel)
  );

endmodule

// File: tb/pkt_stream_buf_tb.sv
`timescale 1ns/1ps
module pkt_stream_buf_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic       hostWrEn, txGo, hostRdEn, radTxPop, rxStart, radRxPush, ackMode;
  logic [7:0] hostWrData, txLenIn, rxLenIn, radRxData;
  logic [7:0] hostRdData, radTxData;
  logic [4:0] txLevel, rxLevel;
  logic       txRoomFlag, rxHalfFlag, txDoneFlag, rxDoneFlag;
  logic       txUnderrunErr, rxOverflowErr;

  always #2.5 clk = ~clk;

  pkt_stream_buf u_dut (
    .clk(clk), .rstN(rstN),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .txGo(txGo), .txLenIn(txLenIn),
    .hostRdEn(hostRdEn), .hostRdData(hostRdData),
    .radTxPop(radTxPop), .radTxData(radTxData),
    .rxStart(rxStart), .rxLenIn(rxLenIn),
    .radRxPush(radRxPush), .radRxData(radRxData),
    .ackMode(ackMode),
    .txLevel(txLevel), .rxLevel(rxLevel),
    .txRoomFlag(txRoomFlag), .rxHalfFlag(rxHalfFlag),
    .txDoneFlag(txDoneFlag), .rxDoneFlag(rxDoneFlag),
    .txUnderrunErr(txUnderrunErr), .rxOverflowErr(rxOverflowErr)
  );

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;

  // Reference model state
  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];
  bit mTxActive, mTxDone, mTxUnd, mRxActive, mRxDone, mRxOvf;
  int mTxLen, mTxSent, mRxLen, mRxCnt;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      summary();
    end
  end

  task automatic idle();
    hostWrEn = 0; hostWrData = 0; txGo = 0; txLenIn = 0; hostRdEn = 0;
    radTxPop = 0; rxStart = 0; rxLenIn = 0; radRxPush = 0; radRxData = 0;
    ackMode = 0;
  endtask

  function automatic bit expRoom(); return (16 - txQ.size()) >= 8; endfunction
  function automatic bit expHalf(); return rxQ.size() >= 8; endfunction

  task automatic compareAll();
    chk(int'(txLevel) == txQ.size(), "R1 txLevel", int'(txLevel), txQ.size());
    chk(int'(rxLevel) == rxQ.size(), "R7 rxLevel", int'(rxLevel), rxQ.size());
    chk(txRoomFlag == expRoom(), "R4 txRoomFlag", int'(txRoomFlag), int'(expRoom()));
    chk(rxHalfFlag == expHalf(), "R5 rxHalfFlag", int'(rxHalfFlag), int'(expHalf()));
    chk(txDoneFlag == mTxDone, "R2 txDoneFlag", int'(txDoneFlag), int'(mTxDone));
    chk(rxDoneFlag == mRxDone, "R6 rxDoneFlag", int'(rxDoneFlag), int'(mRxDone));
    chk(txUnderrunErr == mTxUnd, "R8 txUnderrunErr", int'(txUnderrunErr), int'(mTxUnd));
    chk(rxOverflowErr == mRxOvf, "R7 rxOverflowErr", int'(rxOverflowErr), int'(mRxOvf));
  endtask

  // One clock: data checks before the edge, model update, compare after it
  task automatic cycle();
    int  txSz;
    int  rxSz;
    bit  pop;
    bit  push;
    #1;
    txSz = txQ.size();
    rxSz = rxQ.size();
    pop  = radTxPop  && mTxActive && !ackMode && !txGo;
    push = radRxPush && mRxActive && !ackMode && !rxStart;
    if (pop && txSz > 0)
      chk(radTxData == txQ[0], "R3 radTxData order", int'(radTxData), int'(txQ[0]));
    if (hostRdEn && rxSz > 0)
      chk(hostRdData == rxQ[0], "R6 hostRdData order", int'(hostRdData), int'(rxQ[0]));
    if (pop && txSz > 0) void'(txQ.pop_front());
    if (hostWrEn && txSz < 16) txQ.push_back(hostWrData);
    if (txGo) begin
      mTxLen = int'(txLenIn); mTxSent = 0; mTxActive = (txLenIn != 0);
      mTxDone = (txLenIn == 0); mTxUnd = 0;
    end else if (pop) begin
      if (txSz == 0) mTxUnd = 1;
      else begin
        mTxSent++;
        if (mTxSent == mTxLen) begin mTxActive = 0; mTxDone = 1; end
      end
    end
    if (hostRdEn && rxSz > 0) void'(rxQ.pop_front());
    if (push && rxSz < 16) rxQ.push_back(radRxData);
    if (rxStart) begin
      mRxLen = int'(rxLenIn); mRxCnt = 0; mRxActive = (rxLenIn != 0);
      mRxDone = (rxLenIn == 0); mRxOvf = 0;
    end else if (push) begin
      mRxCnt++;
      if (rxSz == 16) mRxOvf = 1;
      if (mRxCnt == mRxLen) begin mRxActive = 0; mRxDone = 1; end
    end
    @(posedge clk);
    #1;
    compareAll();
  endtask

  function automatic logic [7:0] pickLen();
    int r = $urandom % 4;
    if (r == 0) return 8'($urandom % 17);
    return 8'(17 + ($urandom % 239));
  endfunction

  task automatic randomPhase(input int n, input bit slowHost);
    for (int i = 0; i < n; i++) begin
      idle();
      hostWrEn   = slowHost ? ($urandom % 6 == 0) : ($urandom % 4 != 0);
      hostWrData = 8'($urandom);
      txGo       = !mTxActive && ($urandom % 12 == 0);
      txLenIn    = pickLen();
      radTxPop   = mTxActive ? ($urandom % 3 == 0) : ($urandom % 20 == 0);
      ackMode    = ($urandom % 25 == 0);
      rxStart    = !mRxActive && ($urandom % 12 == 0);
      rxLenIn    = pickLen();
      radRxPush  = mRxActive ? ($urandom % 2 == 0) : ($urandom % 20 == 0);
      radRxData  = 8'($urandom);
      hostRdEn   = slowHost ? ($urandom % 6 == 0) : ($urandom % 3 != 0);
      cycle();
    end
  endtask

  initial begin
    int lvlTx;
    int lvlRx;
    void'($urandom(32'h0005eed1));
    idle();
    rstN = 0;
    repeat (4) @(posedge clk);
    #1 rstN = 1;
    @(posedge clk);
    #1;
    // R11: reset state
    chk(txLevel == 0 && rxLevel == 0, "R11 levels after reset", int'(txLevel), 0);
    chk(txRoomFlag == 1, "R11 txRoomFlag after reset", int'(txRoomFlag), 1);
    chk({rxHalfFlag, txDoneFlag, rxDoneFlag, txUnderrunErr, rxOverflowErr} == 0,
        "R11 flags after reset",
        int'({rxHalfFlag, txDoneFlag, rxDoneFlag, txUnderrunErr, rxOverflowErr}), 0);

    // R1: 17 writes, the last one dropped
    for (int i = 0; i < 17; i++) begin
      idle(); hostWrEn = 1; hostWrData = 8'(i + 8'h40); cycle();
    end
    chk(txLevel == 16, "R1 full buffer drops write", int'(txLevel), 16);

    // R2: short packet sent with no further host action
    idle(); txGo = 1; txLenIn = 8'd16; cycle();
    for (int i = 0; i < 16; i++) begin
      idle(); radTxPop = 1; cycle();
    end
    chk(txDoneFlag == 1, "R2 short packet done", int'(txDoneFlag), 1);

    // R10: pop while idle ignored; host read of empty rx ignored
    idle(); hostWrEn = 1; hostWrData = 8'hA5; cycle();
    idle(); radTxPop = 1; hostRdEn = 1; cycle();
    chk(txLevel == 1, "R10 idle pop ignored", int'(txLevel), 1);
    chk(rxLevel == 0, "R1 empty read ignored", int'(rxLevel), 0);

    // R8: underrun after the single byte is consumed
    idle(); txGo = 1; txLenIn = 8'd3; cycle();
    idle(); radTxPop = 1; cycle();
    idle(); radTxPop = 1; cycle();
    chk(txUnderrunErr == 1, "R8 underrun set", int'(txUnderrunErr), 1);
    idle(); cycle();
    chk(txUnderrunErr == 1, "R8 underrun sticky", int'(txUnderrunErr), 1);
    idle(); txGo = 1; txLenIn = 8'd0; cycle();
    chk(txUnderrunErr == 0 && txDoneFlag == 1, "R8 cleared by txGo, R2 zero length",
        int'({txUnderrunErr, txDoneFlag}), 1);

    // R7 / R6: 20-byte frame, host does not read -> overflow, still completes
    idle(); rxStart = 1; rxLenIn = 8'd20; cycle();
    for (int i = 0; i < 20; i++) begin
      idle(); radRxPush = 1; radRxData = 8'(8'h80 + i); cycle();
    end
    chk(rxLevel == 16 && rxOverflowErr == 1, "R7 overflow drops byte",
        int'(rxLevel), 16);
    chk(rxDoneFlag == 1, "R6 rx done at length", int'(rxDoneFlag), 1);
    for (int i = 0; i < 16; i++) begin
      idle(); hostRdEn = 1; cycle();
    end

    // R9: ACK phase freezes both buffers
    for (int i = 0; i < 4; i++) begin
      idle(); hostWrEn = 1; hostWrData = 8'(i); cycle();
    end
    idle(); txGo = 1; txLenIn = 8'd4; rxStart = 1; rxLenIn = 8'd4; cycle();
    idle(); radRxPush = 1; radRxData = 8'h11; cycle();
    lvlTx = int'(txLevel);
    lvlRx = int'(rxLevel);
    for (int i = 0; i < 5; i++) begin
      idle(); ackMode = 1; radTxPop = 1; radRxPush = 1; radRxData = 8'hEE; cycle();
    end
    chk(int'(txLevel) == lvlTx, "R9 ack keeps tx", int'(txLevel), lvlTx);
    chk(int'(rxLevel) == lvlRx, "R9 ack keeps rx", int'(rxLevel), lvlRx);
    idle(); hostRdEn = 1; cycle();
    for (int i = 0; i < 4; i++) begin
      idle(); radTxPop = 1; cycle();
    end

    // Random streaming traffic: long packets, refills, drains
    randomPhase(4000, 1'b0);
    randomPhase(2000, 1'b1);
    randomPhase(2000, 1'b0);

    summary();
  end

endmodule